// File: doc/BRIEF.md
# Two-Register Byte Microcontroller Core

This block is a small single-issue processor core. It has two 8-bit working registers (called R0 and R1 here), a one-bit carry flag and an 8-bit instruction pointer. Every instruction is a single byte. The core fetches it from a 256-byte code memory and may read or write a 16-byte data memory. Both memories are synchronous arrays outside the core. Each returns read data on the clock edge after the request.

Each instruction takes a fetch cycle and an execute cycle. A load adds a third cycle, in which the returned byte is written into the register. The instruction pointer addresses the instruction to fetch and moves on after every instruction. The core has no other way to read or write it. All arithmetic and compare results come from a separate ALU unit.

A two-flop synchroniser releases the asynchronous active-low reset. The core issues its first fetch, from address 0, in the first cycle after that release.

Top module: `duo_core`

## Requirements
- R1: While reset is held, the core issues no code read, no data read and no data write. After reset, R0, R1, carry and the instruction pointer are all zero, and the first fetch is from code address 0x00.
- R2: A fetch drives `code_rd` for exactly one cycle with `code_addr` equal to the instruction pointer. The instruction is executed in the following cycle. An instruction that is not a taken jump sets the next fetch address to the previous one plus 1, modulo 256.
- R3: Byte `00 M R A3..A0` moves data between data address A (bits 3:0) and the register chosen by bit 4 (0 = R0, 1 = R1). With bit 5 = 1, a store drives `data_we`, the address and the register value in the execute cycle. With bit 5 = 0, a load drives `data_rd` in the execute cycle and writes the returned byte into the register in the next cycle.
- R4: Byte `01 H R I3..I0` writes the immediate I into one nibble of the register chosen by bit 4: the low nibble when bit 5 = 0, the high nibble when bit 5 = 1. The other nibble keeps its value.
- R5: Any byte `10 C D O3..O0` that R6 and R7 do not claim is a relative jump. The new pointer is (IP+1)+O when bit 4 = 1, or (IP+1)-O when bit 4 = 0, modulo 256. With bit 5 = 1, the jump is taken only if carry is set; otherwise execution falls through to IP+1.
- R6: Bytes `100000 R C` jump to the address held in R0 (bit 1 = 0) or R1 (bit 1 = 1). The jump is unconditional when bit 0 = 0 and taken only with carry set when bit 0 = 1. These bytes take priority over R5.
- R7: Bytes 0x84, 0x85 and 0x86 set carry to R0==R1, R0>R1 and R0<R1 respectively, comparing unsigned. Byte 0x87 inverts carry. None of them changes a register.
- R8: Bytes 0xC0/0xC1 increment R0/R1, and bytes 0xC2/0xC3 decrement R0/R1, modulo 256. Carry becomes 1 exactly when the result is zero.
- R9: Byte 0xC4 writes R0+R1 into R0, with carry set to the carry out of bit 7. Byte 0xC5 writes R0-R1 into R0, with carry set to the borrow (R0<R1).
- R10: Bytes 0xC6, 0xC7, 0xC8 and 0xC9 write R0 AND, OR, XOR and XNOR R1 into R0. Carry is unchanged.
- R11: Bytes 0xCA/0xCB invert every bit of R0/R1. Carry is unchanged.
- R12: Bytes 0xCC to 0xFF only advance the pointer. They make no data access and change no register and no carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_rd | output | 1 | Code memory read request |
| code_addr | output | 8 | Code memory address (instruction pointer) |
| code_rdata | input | 8 | Instruction byte, valid the cycle after `code_rd` |
| data_rd | output | 1 | Data memory read request |
| data_we | output | 1 | Data memory write strobe |
| data_addr | output | 4 | Data memory address |
| data_wdata | output | 8 | Data memory write value |
| data_rdata | input | 8 | Data memory read value, valid the cycle after `data_rd` |

## Verification
The first fetch is due two clock edges after `rst_n` rises. An instruction byte is consumed one cycle after its fetch, and the store strobe or load request for that instruction appears in that same execute cycle. A loaded byte lands in its register one cycle later again, and a register, carry or pointer update only becomes visible at the next store or fetch address. The bench's behavioural model steps through these same cycle positions on every rising edge and compares the full port bundle in the middle of each cycle. Directed end-of-program memory contents then pin down the values of each instruction class.

// File: rtl/duo_pkg.sv
package duo_pkg;

  localparam int unsigned INSN_W  = 8;
  localparam int unsigned FIELD_W = 4;

  typedef enum logic [2:0] {
    K_NOP, K_LOAD, K_STORE, K_IMM, K_NEAR, K_FAR, K_ALU
  } kind_e;

  typedef enum logic [3:0] {
    A_NONE, A_EQ, A_GT, A_LT, A_CNOT, A_INC, A_DEC, A_ADD,
    A_SUB, A_AND, A_OR, A_XOR, A_XNOR, A_CPL
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_FETCH, ST_EXEC, ST_WB
  } state_e;

  typedef struct packed {
    kind_e                kind;
    alu_op_e              alu;
    logic                 rsel;
    logic                 hi;
    logic                 cond;
    logic                 fwd;
    logic [FIELD_W-1:0]   field;
  } dec_t;

endpackage

// File: rtl/duo_decode.sv
module duo_decode
  import duo_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);

  always_comb begin
    dec       = '0;
    dec.kind  = K_NOP;
    dec.alu   = A_NONE;
    dec.field = insn[FIELD_W-1:0];
    unique case (insn[7:6])
      2'b00: begin
        dec.kind = insn[5] ? K_STORE : K_LOAD;
        dec.rsel = insn[4];
      end
      2'b01: begin
        dec.kind = K_IMM;
        dec.hi   = insn[5];
        dec.rsel = insn[4];
      end
      2'b10: begin
        // register-indirect jumps and compares win over relative jumps
        if (insn[5:3] == 3'b000) begin
          if (insn[2]) begin
            dec.kind = K_ALU;
            unique case (insn[1:0])
              2'b00:   dec.alu = A_EQ;
              2'b01:   dec.alu = A_GT;
              2'b10:   dec.alu = A_LT;
              default: dec.alu = A_CNOT;
            endcase
          end else begin
            dec.kind = K_FAR;
            dec.rsel = insn[1];
            dec.cond = insn[0];
          end
        end else begin
          dec.kind = K_NEAR;
          dec.cond = insn[5];
          dec.fwd  = insn[4];
        end
      end
      default: begin
        dec.rsel = insn[0];
        casez (insn[5:0])
          6'b00000?: begin dec.kind = K_ALU; dec.alu = A_INC;  end
          6'b00001?: begin dec.kind = K_ALU; dec.alu = A_DEC;  end
          6'b000100: begin dec.kind = K_ALU; dec.alu = A_ADD;  end
          6'b000101: begin dec.kind = K_ALU; dec.alu = A_SUB;  end
          6'b000110: begin dec.kind = K_ALU; dec.alu = A_AND;  end
          6'b000111: begin dec.kind = K_ALU; dec.alu = A_OR;   end
          6'b001000: begin dec.kind = K_ALU; dec.alu = A_XOR;  end
          6'b001001: begin dec.kind = K_ALU; dec.alu = A_XNOR; end
          6'b00101?: begin dec.kind = K_ALU; dec.alu = A_CPL;  end
          default:   dec.kind = K_NOP;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/duo_alu.sv
module duo_alu
  import duo_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op,
  input  logic          rsel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          res_we,
  output logic          res_dst,
  output logic          c_out,
  output logic          c_we
);

  logic [DW-1:0] src;
  logic [DW:0]   sum;
  logic [DW:0]   diff;

  assign src  = rsel ? b : a;
  assign sum  = {1'b0, a} + {1'b0, b};
  assign diff = {1'b0, a} - {1'b0, b};

  always_comb begin
    res     = '0;
    res_we  = 1'b0;
    res_dst = 1'b0;
    c_out   = c_in;
    c_we    = 1'b0;
    unique case (op)
      A_EQ:   begin c_we = 1'b1; c_out = (a == b); end
      A_GT:   begin c_we = 1'b1; c_out = (a > b);  end
      A_LT:   begin c_we = 1'b1; c_out = (a < b);  end
      A_CNOT: begin c_we = 1'b1; c_out = ~c_in;    end
      A_INC, A_DEC: begin
        res     = (op == A_INC) ? src + DW'(1) : src - DW'(1);
        res_we  = 1'b1;
        res_dst = rsel;
        c_we    = 1'b1;
        c_out   = (res == '0);
      end
      A_ADD:  begin res = sum[DW-1:0];  res_we = 1'b1; c_we = 1'b1; c_out = sum[DW];  end
      A_SUB:  begin res = diff[DW-1:0]; res_we = 1'b1; c_we = 1'b1; c_out = diff[DW]; end
      A_AND:  begin res = a & b;        res_we = 1'b1; end
      A_OR:   begin res = a | b;        res_we = 1'b1; end
      A_XOR:  begin res = a ^ b;        res_we = 1'b1; end
      A_XNOR: begin res = ~(a ^ b);     res_we = 1'b1; end
      A_CPL:  begin res = ~src;         res_we = 1'b1; res_dst = rsel; end
      default: ;
    endcase
  end

endmodule

// File: rtl/duo_nextip.sv
module duo_nextip
  import duo_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0]      ip,
  input  kind_e              kind,
  input  logic               cond,
  input  logic               fwd,
  input  logic [FIELD_W-1:0] off,
  input  logic               carry,
  input  logic [AW-1:0]      far_tgt,
  output logic [AW-1:0]      nip
);

  logic [AW-1:0] seq;
  logic          taken;

  assign seq   = ip + AW'(1);
  assign taken = ~cond | carry;

  always_comb begin
    nip = seq;
    if (kind == K_NEAR && taken)
      nip = fwd ? seq + AW'(off) : seq - AW'(off);
    else if (kind == K_FAR && taken)
      nip = far_tgt;
  end

endmodule

// File: rtl/duo_core.sv
module duo_core
  import duo_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CODE_AW    = 8,
  parameter int unsigned DATA_AW    = 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               code_rd,
  output logic [CODE_AW-1:0] code_addr,
  input  logic [DATA_W-1:0]  code_rdata,
  output logic               data_rd,
  output logic               data_we,
  output logic [DATA_AW-1:0] data_addr,
  output logic [DATA_W-1:0]  data_wdata,
  input  logic [DATA_W-1:0]  data_rdata
);

  localparam int unsigned LO_W = DATA_W - FIELD_W;

  // reset release synchroniser
  logic [RST_STAGES-1:0] sync_q;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = sync_q[RST_STAGES-1];

  state_e              state_q, state_d;
  logic [CODE_AW-1:0]  ip_q, ip_nxt;
  logic [DATA_W-1:0]   r0_q, r1_q, r0_d, r1_d;
  logic                c_q, c_d, ld_sel_q;
  logic                ip_en, r0_en, r1_en, c_en, sel_en;

  dec_t                dec;
  logic [DATA_W-1:0]   sel_reg, imm_val, alu_res;
  logic                alu_we, alu_dst, alu_c, alu_cwe;

  duo_decode u_dec (
    .insn (code_rdata),
    .dec  (dec)
  );

  assign sel_reg = dec.rsel ? r1_q : r0_q;
  assign imm_val = dec.hi ? {dec.field, sel_reg[LO_W-1:0]}
                          : {sel_reg[DATA_W-1:FIELD_W], dec.field};

  duo_alu #(.DW(DATA_W)) u_alu (
    .op      (dec.kind == K_ALU ? dec.alu : A_NONE),
    .rsel    (dec.rsel),
    .a       (r0_q),
    .b       (r1_q),
    .c_in    (c_q),
    .res     (alu_res),
    .res_we  (alu_we),
    .res_dst (alu_dst),
    .c_out   (alu_c),
    .c_we    (alu_cwe)
  );

  duo_nextip #(.AW(CODE_AW)) u_nip (
    .ip      (ip_q),
    .kind    (dec.kind),
    .cond    (dec.cond),
    .fwd     (dec.fwd),
    .off     (dec.field),
    .carry   (c_q),
    .far_tgt (CODE_AW'(sel_reg)),
    .nip     (ip_nxt)
  );

  // next-state and enables
  always_comb begin
    state_d = state_q;
    ip_en   = 1'b0;
    r0_en   = 1'b0;
    r1_en   = 1'b0;
    c_en    = 1'b0;
    sel_en  = 1'b0;
    r0_d    = alu_res;
    r1_d    = alu_res;
    c_d     = alu_c;
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC: begin
        ip_en   = 1'b1;
        state_d = (dec.kind == K_LOAD) ? ST_WB : ST_FETCH;
        unique case (dec.kind)
          K_LOAD: sel_en = 1'b1;
          K_IMM: begin
            r0_en = ~dec.rsel;
            r1_en = dec.rsel;
            r0_d  = imm_val;
            r1_d  = imm_val;
          end
          K_ALU: begin
            r0_en = alu_we & ~alu_dst;
            r1_en = alu_we & alu_dst;
            c_en  = alu_cwe;
          end
          default: ;
        endcase
      end
      ST_WB: begin
        state_d = ST_FETCH;
        r0_en   = ~ld_sel_q;
        r1_en   = ld_sel_q;
        r0_d    = data_rdata;
        r1_d    = data_rdata;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q  <= ST_FETCH;
      ip_q     <= '0;
      r0_q     <= '0;
      r1_q     <= '0;
      c_q      <= 1'b0;
      ld_sel_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ip_en)  ip_q     <= ip_nxt;
      if (r0_en)  r0_q     <= r0_d;
      if (r1_en)  r1_q     <= r1_d;
      if (c_en)   c_q      <= c_d;
      if (sel_en) ld_sel_q <= dec.rsel;
    end
  end

  assign code_rd    = core_rst_n && (state_q == ST_FETCH);
  assign code_addr  = ip_q;
  assign data_rd    = (state_q == ST_EXEC) && (dec.kind == K_LOAD);
  assign data_we    = (state_q == ST_EXEC) && (dec.kind == K_STORE);
  assign data_addr  = dec.field[DATA_AW-1:0];
  assign data_wdata = sel_reg;

endmodule

// File: rtl/duo_core_chk.sv
module duo_core_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CODE_AW = 8,
  parameter int unsigned DATA_AW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               code_rd,
  input logic [CODE_AW-1:0] code_addr,
  input logic [DATA_W-1:0]  code_rdata,
  input logic               data_rd,
  input logic               data_we,
  input logic [DATA_AW-1:0] data_addr
);

  logic               exec_q, seen_q;
  logic [CODE_AW-1:0] fa_q;
  logic [DATA_W-1:0]  ins_q;
  logic [CODE_AW-1:0] seq_addr, fwd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      exec_q <= code_rd;
      if (exec_q) seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (code_rd) fa_q  <= code_addr;
    if (exec_q)  ins_q <= code_rdata;
  end

  assign seq_addr = fa_q + CODE_AW'(1);
  assign fwd_addr = seq_addr + CODE_AW'(ins_q[3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_quiet_in_reset_R1: assert (!code_rd && !data_rd && !data_we)
        else $error("core active during reset");
    end
  end

  assert_fetch_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_rd |=> !code_rd);

  assert_step_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_rd && seen_q && ins_q[6]) |-> code_addr == seq_addr);

  assert_near_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_rd && seen_q && ins_q[7:4] == 4'b1001) |-> code_addr == fwd_addr);

  assert_access_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_rd && data_we) && !(code_rd && (data_rd || data_we)));

  assert_store_enc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> (code_rdata[7:5] == 3'b001 && data_addr == code_rdata[DATA_AW-1:0]));

  assert_load_enc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> (code_rdata[7:5] == 3'b000 && data_addr == code_rdata[DATA_AW-1:0]));

endmodule

bind duo_core duo_core_chk #(
  .DATA_W  (DATA_W),
  .CODE_AW (CODE_AW),
  .DATA_AW (DATA_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_rd    (code_rd),
  .code_addr  (code_addr),
  .code_rdata (code_rdata),
  .data_rd    (data_rd),
  .data_we    (data_we),
  .data_addr  (data_addr)
);

// File: tb/duo_core_bench.sv
module duo_core_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       code_rd, data_rd, data_we;
  logic [7:0] code_addr, code_q, data_q, data_wdata;
  logic [3:0] data_addr;

  logic [7:0] cmem [256];
  logic [7:0] dmem [16];
  int         dmodel [16];

  int n_chk = 0;
  int n_bad = 0;

  // behavioural model state
  int m_live, m_phase, m_ip, m_c, m_first, m_ldv, m_lds;
  int m_r [2];

  always #5 clk = ~clk;

  duo_core u_duo_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_rd    (code_rd),
    .code_addr  (code_addr),
    .code_rdata (code_q),
    .data_rd    (data_rd),
    .data_we    (data_we),
    .data_addr  (data_addr),
    .data_wdata (data_wdata),
    .data_rdata (data_q)
  );

  always @(posedge clk) begin
    if (code_rd) code_q <= cmem[code_addr];
    if (data_rd) data_q <= dmem[data_addr];
    if (data_we) dmem[data_addr] <= data_wdata;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int ins);
    int lo;
    lo = ins & 63;
    case (ins >> 6)
      0: return "R3";
      1: return "R4";
      2: begin
        if (((ins >> 3) & 7) != 0) return "R5";
        if ((ins >> 2) & 1)        return "R7";
        return "R6";
      end
      default: begin
        if (lo < 4)   return "R8";
        if (lo < 6)   return "R9";
        if (lo < 10)  return "R10";
        if (lo < 12)  return "R11";
        return "R12";
      end
    endcase
  endfunction

  function automatic int pack(input int crd, input int caddr, input int drd,
                              input int dwe, input int daddr, input int wd);
    return (crd << 24) | ((crd != 0 ? caddr : 0) << 16) | (drd << 13) | (dwe << 12)
         | (((drd | dwe) != 0 ? daddr : 0) << 8) | (dwe != 0 ? wd : 0);
  endfunction

  task automatic model_exec();
    int ins, seq, nxt, s, a, b, t;
    ins = int'(cmem[m_ip]);
    seq = (m_ip + 1) & 255;
    nxt = seq;
    s = (ins >> 4) & 1;
    m_phase = 0;
    case (ins >> 6)
      0: begin
        if ((ins >> 5) & 1) dmodel[ins & 15] = m_r[s];
        else begin m_ldv = dmodel[ins & 15]; m_lds = s; m_phase = 2; end
      end
      1: begin
        if ((ins >> 5) & 1) m_r[s] = (m_r[s] & 15) | ((ins & 15) << 4);
        else                m_r[s] = (m_r[s] & 240) | (ins & 15);
      end
      2: begin
        if (((ins >> 3) & 7) == 0) begin
          if ((ins >> 2) & 1) begin
            case (ins & 3)
              0: m_c = (m_r[0] == m_r[1]) ? 1 : 0;
              1: m_c = (m_r[0] >  m_r[1]) ? 1 : 0;
              2: m_c = (m_r[0] <  m_r[1]) ? 1 : 0;
              default: m_c = 1 - m_c;
            endcase
          end else if ((ins & 1) == 0 || m_c != 0) nxt = m_r[(ins >> 1) & 1];
        end else if (((ins >> 5) & 1) == 0 || m_c != 0)
          nxt = ((ins >> 4) & 1) ? (seq + (ins & 15)) & 255 : (seq - (ins & 15)) & 255;
      end
      default: begin
        a = m_r[0]; b = m_r[1]; t = ins & 1;
        case (ins & 63)
          0, 1:   begin m_r[t] = (m_r[t] + 1) & 255; m_c = (m_r[t] == 0) ? 1 : 0; end
          2, 3:   begin m_r[t] = (m_r[t] - 1) & 255; m_c = (m_r[t] == 0) ? 1 : 0; end
          4:      begin m_c = (a + b > 255) ? 1 : 0; m_r[0] = (a + b) & 255; end
          5:      begin m_c = (a < b) ? 1 : 0;       m_r[0] = (a - b) & 255; end
          6:      m_r[0] = a & b;
          7:      m_r[0] = a | b;
          8:      m_r[0] = a ^ b;
          9:      m_r[0] = (~(a ^ b)) & 255;
          10, 11: m_r[t] = (~m_r[t]) & 255;
          default: ;
        endcase
      end
    endcase
    m_ip = nxt;
  endtask

  // model advances on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 0; m_phase = 0; m_ip = 0; m_c = 0; m_first = 1;
      m_r[0] = 0; m_r[1] = 0; m_ldv = 0; m_lds = 0;
    end else if (m_live < 2) begin
      m_live++;
    end else begin
      case (m_phase)
        0: begin m_phase = 1; m_first = 0; end
        1: model_exec();
        default: begin m_r[m_lds] = m_ldv; m_phase = 0; end
      endcase
    end
  end

  // compare in mid-cycle
  always @(negedge clk) begin
    int ins, act, exp, crd, drd, dwe;
    string tg;
    if (!rst_n) begin
      check(!code_rd && !data_rd && !data_we, "R1", "quiet in reset",
            {code_rd, data_rd, data_we}, 0);
    end else begin
      ins = int'(cmem[m_ip]);
      crd = (m_live >= 2 && m_phase == 0) ? 1 : 0;
      drd = (m_live >= 2 && m_phase == 1 && (ins >> 6) == 0 && ((ins >> 5) & 1) == 0) ? 1 : 0;
      dwe = (m_live >= 2 && m_phase == 1 && (ins >> 6) == 0 && ((ins >> 5) & 1) == 1) ? 1 : 0;
      exp = pack(crd, m_ip, drd, dwe, ins & 15, m_r[(ins >> 4) & 1]);
      act = pack(int'(code_rd), int'(code_addr), int'(data_rd), int'(data_we),
                 int'(data_addr), int'(data_wdata));
      if (m_live < 2 || m_phase == 0) tg = (m_first != 0) ? "R1" : "R2";
      else if (m_phase == 2)          tg = "R3";
      else                            tg = tag_of(ins);
      check(act == exp, tg, "port bundle", act, exp);
    end
  end

  task automatic load_prog_a();
    logic [7:0] p [50];
    p = '{8'h45, 8'h63, 8'h5A, 8'h71, 8'hC4, 8'h20, 8'hC5, 8'hC8, 8'h21, 8'hC9,
          8'h22, 8'hCB, 8'h33, 8'hC5, 8'hB2, 8'h24, 8'h24, 8'h84, 8'h87, 8'hB2,
          8'h25, 8'hC1, 8'h4F, 8'h6F, 8'hC0, 8'hB1, 8'h36, 8'h37, 8'hC2, 8'h28,
          8'h85, 8'h86, 8'h85, 8'h58, 8'h72, 8'h83, 8'h29, 8'h29, 8'h29, 8'h29,
          8'hCC, 8'hFF, 8'hC6, 8'h12, 8'hC7, 8'h2A, 8'h3B, 8'h84, 8'h87, 8'hA1};
    for (int i = 0; i < 256; i++) cmem[i] = 8'hCC;
    for (int i = 0; i < 50; i++)  cmem[i] = p[i];
    for (int i = 0; i < 16; i++) begin dmem[i] = 8'h00; dmodel[i] = 0; end
  endtask

  task automatic expect_mem(input int addr, input int val, input string tag);
    check(int'(dmem[addr]) == val, tag, $sformatf("data[%0d] after program", addr),
          int'(dmem[addr]), val);
  endtask

  initial begin
    rst_n = 1'b0;
    load_prog_a();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (400) @(posedge clk);
    #1;
    expect_mem(0,  8'h4F, "R9");   // 0x35+0x1A
    expect_mem(1,  8'h2F, "R10");  // xor
    expect_mem(2,  8'hCA, "R10");  // xnor
    expect_mem(3,  8'hE5, "R11");  // complement R1
    expect_mem(4,  8'h00, "R5");   // skipped by taken conditional jump
    expect_mem(5,  8'hE5, "R7");   // equal then invert, jump not taken
    expect_mem(6,  8'h00, "R5");   // skipped after increment wrapped to zero
    expect_mem(7,  8'hE6, "R8");   // increment R1
    expect_mem(8,  8'hFF, "R8");   // decrement from zero
    expect_mem(9,  8'h00, "R6");   // skipped by far jump through R1
    expect_mem(10, 8'hEA, "R10");  // and, then or with loaded R1
    expect_mem(11, 8'hCA, "R3");   // loaded byte stored back
    for (int k = 0; k < 4; k++) begin
      #1 rst_n = 1'b0;
      for (int i = 0; i < 256; i++) cmem[i] = 8'($urandom);
      for (int i = 0; i < 16; i++) begin
        dmem[i]   = 8'($urandom);
        dmodel[i] = int'(dmem[i]);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5000) @(posedge clk);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule